// File: doc/BRIEF.md
# Sampling ADC Register Controller

This block sits between a byte-wide host I/O bus and a 12-bit successive-approximation converter. The converter's input comes through a 16-way analog multiplexer and a programmable-gain stage. The host programs the channel, the gain code and the transfer mode through write registers. The host then starts conversions in one of three ways: a software strobe register, a pacer pulse from an on-chip timer, or an asynchronous external trigger pin. A configuration input chooses whether the pacer or the external pin acts as the hardware trigger source.

The converter connects through a plain start/busy/data port. A one-cycle start pulse begins a conversion. The converter raises busy while it works and presents its result when busy falls. The controller then latches the 12-bit result and the channel that was selected at launch. It drives an active-low ready flag low. Depending on the mode, it also raises a sticky interrupt request or emits a one-cycle DMA request. The host reads the high byte (which carries the ready flag) and then the low byte. Reading the low byte re-arms the ready flag.

Top module: `sampling_adc_ctrl`

## Requirements
- R1: Reading offset 4 returns result bits 7..0. Reading offset 5 returns result bits 11..8 in bits 3..0, the ready flag in bit 4, and zeros in bits 7..5.
- R2: The ready flag (offset 5 bit 4) reads 1 after reset and stays 1 until a conversion completes. After a completion it reads 0, and a read of offset 5 leaves it at 0. It returns to 1 only when offset 4 is read.
- R3: A write to offset 10 drives its low nibble onto `muxSel` from the next cycle. Reading offset 10 returns, in bits 3..0, the channel that was selected when the latest latched conversion was launched.
- R4: A write to offset 9 stores a 3-bit gain code from bits 2..0. Codes 0..4 (×1, ×2, ×4, ×8, ×16) are driven onto `gainSel`. Codes 5..7 are kept but raise `gainInvalid`, and `gainSel` is held at 0 for them. Reading offset 9 returns the code in bits 2..0 and the invalid flag in bit 3.
- R5: A write of any value to offset 12 produces exactly one single-cycle `convStart` pulse when no conversion is in progress.
- R6: With `useExtTrig`=0, a `pacerPulse` high cycle launches a conversion and `extTrig` has no effect. With `useExtTrig`=1, a rising edge on `extTrig` launches one, seen through a two-flop synchronizer, and `pacerPulse` has no effect.
- R7: Any trigger that arrives while a conversion is launching or busy is dropped, and no further `convStart` is produced for it.
- R8: With mode bits (offset 11, bits 2..0) = 001, each completion sets `irqReq`. It stays set until offset 8 is written with any value, and a later completion sets it again.
- R9: With mode bits = 010, each completion emits a `dmaReq` pulse exactly one cycle long and leaves `irqReq` low. With mode bits = 000, a completion raises neither.
- R10: After reset, `convStart`, `irqReq`, `dmaReq`, `muxSel`, `gainSel` and `gainInvalid` are 0, offset 5 reads 0x10 and offset 4 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| pacerPulse | input | 1 | Synchronous pacer trigger pulse |
| extTrig | input | 1 | Asynchronous external trigger |
| useExtTrig | input | 1 | 1 selects the external trigger, 0 the pacer |
| convStart | output | 1 | One-cycle converter start |
| convBusy | input | 1 | Converter busy |
| convData | input | 12 | Converter result, valid when busy falls |
| muxSel | output | 4 | Analog multiplexer channel |
| gainSel | output | 3 | Effective gain code for the amplifier |
| gainInvalid | output | 1 | Stored gain code is a reserved value |
| irqReq | output | 1 | Sticky interrupt request |
| dmaReq | output | 1 | One-cycle DMA request |

## Verification
The hardest case to reach is a trigger that lands while a conversion is in flight. From the ports, that needs a second software write or a pacer pulse placed inside the few cycles between the start pulse and the fall of busy. The bench uses a converter model with a fixed busy length so that this window sits at known cycles. It fires a second strobe and a pacer pulse inside the window, then counts start pulses. The same window is used to rewrite the channel mid-conversion, which shows that the channel read back belongs to the launch and not to the latest write.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W  = 12;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 3;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int HI_W   = RES_W - BYTE_W;
  localparam int SYNC_STAGES = 2;

  localparam logic [GAIN_W-1:0] GAIN_MAX = 3'd4;

  localparam logic [ADDR_W-1:0] OFF_LO     = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_HI     = 4'd5;
  localparam logic [ADDR_W-1:0] OFF_IRQCLR = 4'd8;
  localparam logic [ADDR_W-1:0] OFF_GAIN   = 4'd9;
  localparam logic [ADDR_W-1:0] OFF_CHAN   = 4'd10;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 4'd11;
  localparam logic [ADDR_W-1:0] OFF_SWTRIG = 4'd12;

  localparam logic [MODE_W-1:0] XFER_IRQ = 3'b001;
  localparam logic [MODE_W-1:0] XFER_DMA = 3'b010;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LAUNCH, SEQ_CONV} seqState_e;

  typedef struct packed {
    logic wrChan;
    logic wrGain;
    logic wrMode;
    logic launch;
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/sadc_control.sv
module sadc_control
  import sadc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = MODE_W,
  parameter int NSYNC = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic          pacerPulse,
  input  logic          extTrig,
  input  logic          useExtTrig,
  input  logic          convBusy,
  input  logic [MW-1:0] modeBits,
  output ctrlStrobe_t   strobe,
  output logic          convStart,
  output logic          readyN,
  output logic          irqReq,
  output logic          dmaReq
);
  seqState_e seqState;
  logic [NSYNC-1:0] extSync;
  logic extPrev, extRise, hwTrig, swTrig, clrIrq, rdLow;

  // address decode
  assign swTrig = busWrEn && (busAddr == OFF_SWTRIG);
  assign clrIrq = busWrEn && (busAddr == OFF_IRQCLR);
  assign rdLow  = busRdEn && (busAddr == OFF_LO);

  always_comb begin
    strobe.wrChan  = busWrEn && (busAddr == OFF_CHAN);
    strobe.wrGain  = busWrEn && (busAddr == OFF_GAIN);
    strobe.wrMode  = busWrEn && (busAddr == OFF_MODE);
    strobe.launch  = (seqState == SEQ_IDLE) && (swTrig || hwTrig);
    strobe.capture = (seqState == SEQ_CONV) && !convBusy;
  end

  // external trigger synchronizer and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      extSync <= {extSync[NSYNC-2:0], extTrig};
      extPrev <= extSync[NSYNC-1];
    end
  end
  assign extRise = extSync[NSYNC-1] && !extPrev;
  assign hwTrig  = useExtTrig ? extRise : pacerPulse;

  // conversion sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState  <= SEQ_IDLE;
      convStart <= 1'b0;
    end else begin
      convStart <= strobe.launch;
      unique case (seqState)
        SEQ_IDLE:   if (strobe.launch) seqState <= SEQ_LAUNCH;
        SEQ_LAUNCH: if (convBusy) seqState <= SEQ_CONV;
        SEQ_CONV:   if (!convBusy) seqState <= SEQ_IDLE;
        default:    seqState <= SEQ_IDLE;
      endcase
    end
  end

  // ready flag, interrupt and DMA request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyN <= 1'b1;
      irqReq <= 1'b0;
      dmaReq <= 1'b0;
    end else begin
      if (strobe.capture) readyN <= 1'b0;
      else if (rdLow)     readyN <= 1'b1;
      if (strobe.capture && modeBits == XFER_IRQ) irqReq <= 1'b1;
      else if (clrIrq)                            irqReq <= 1'b0;
      dmaReq <= strobe.capture && (modeBits == XFER_DMA);
    end
  end

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |-> !convStart);
  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!readyN && !rdLow) |=> !readyN);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrIrq && !strobe.capture) |=> !irqReq);
  assert_dma_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq);
endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int CW = CHAN_W,
  parameter int GW = GAIN_W,
  parameter int MW = MODE_W,
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] busAddr,
  input  logic [BW-1:0] wrData,
  input  logic [RW-1:0] convData,
  input  logic          readyN,
  output logic [BW-1:0] rdData,
  output logic [CW-1:0] muxSel,
  output logic [GW-1:0] gainSel,
  output logic          gainInvalid,
  output logic [MW-1:0] modeBits
);
  localparam int HW = RW - BW;
  localparam int PAD_HI = BW - 1 - HW;

  logic [GW-1:0] gainCode;
  logic [CW-1:0] launchChan, sampleChan;
  logic [RW-1:0] result;
  logic unusedWrHigh;

  assign unusedWrHigh = ^wrData[BW-1:CW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxSel     <= '0;
      gainCode   <= '0;
      modeBits   <= '0;
      launchChan <= '0;
      sampleChan <= '0;
      result     <= '0;
    end else begin
      if (strobe.wrChan)  muxSel     <= wrData[CW-1:0];
      if (strobe.wrGain)  gainCode   <= wrData[GW-1:0];
      if (strobe.wrMode)  modeBits   <= wrData[MW-1:0];
      if (strobe.launch)  launchChan <= muxSel;
      if (strobe.capture) begin
        result     <= convData;
        sampleChan <= launchChan;
      end
    end
  end

  assign gainInvalid = gainCode > GAIN_MAX;
  assign gainSel     = gainInvalid ? '0 : gainCode;

  always_comb begin
    rdData = '0;
    unique case (busAddr)
      OFF_LO:   rdData = result[BW-1:0];
      OFF_HI:   rdData = {{PAD_HI{1'b0}}, readyN, result[RW-1:BW]};
      OFF_GAIN: rdData = BW'({gainInvalid, gainCode});
      OFF_CHAN: rdData = BW'(sampleChan);
      default:  rdData = '0;
    endcase
  end

  assert_gain_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    gainSel <= GAIN_MAX);
  assert_chan_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrChan |=> (muxSel == $past(wrData[CW-1:0])));
  assert_result_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(result));
endmodule

// File: rtl/sampling_adc_ctrl.sv
module sampling_adc_ctrl
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              pacerPulse,
  input  logic              extTrig,
  input  logic              useExtTrig,
  output logic              convStart,
  input  logic              convBusy,
  input  logic [RES_W-1:0]  convData,
  output logic [CHAN_W-1:0] muxSel,
  output logic [GAIN_W-1:0] gainSel,
  output logic              gainInvalid,
  output logic              irqReq,
  output logic              dmaReq
);
  ctrlStrobe_t strobe;
  logic readyN;
  logic [MODE_W-1:0] modeBits;

  sadc_control u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .pacerPulse(pacerPulse), .extTrig(extTrig),
    .useExtTrig(useExtTrig), .convBusy(convBusy), .modeBits(modeBits),
    .strobe(strobe), .convStart(convStart), .readyN(readyN),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  sadc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .wrData(busWrData), .convData(convData), .readyN(readyN),
    .rdData(busRdData), .muxSel(muxSel), .gainSel(gainSel),
    .gainInvalid(gainInvalid), .modeBits(modeBits)
  );
endmodule

// File: tb/sim_sampling_adc_ctrl.sv
module sim_sampling_adc_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0, busRdData;
  logic pacerPulse = 1'b0, extTrig = 1'b0, useExtTrig = 1'b0;
  logic convStart, convBusy, gainInvalid, irqReq, dmaReq;
  logic [11:0] convData, modelValue = '0;
  logic [3:0] muxSel;
  logic [2:0] gainSel;
  logic [2:0] busyCnt;
  int testsRun = 0, testsFailed = 0, startCount = 0, dmaCount = 0;

  always #4 clk = ~clk;

  sampling_adc_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pacerPulse(pacerPulse), .extTrig(extTrig), .useExtTrig(useExtTrig),
    .convStart(convStart), .convBusy(convBusy), .convData(convData),
    .muxSel(muxSel), .gainSel(gainSel), .gainInvalid(gainInvalid),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  // converter model: busy for five cycles after a start pulse
  assign convData = modelValue;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convBusy <= 1'b0;
      busyCnt  <= '0;
    end else if (convStart && !convBusy) begin
      convBusy <= 1'b1;
      busyCnt  <= 3'd4;
    end else if (convBusy) begin
      if (busyCnt == 0) convBusy <= 1'b0;
      else busyCnt <= busyCnt - 1'b1;
    end
  end
  always @(posedge clk) begin
    if (rstN && convStart) startCount++;
    if (rstN && dmaReq) dmaCount++;
  end

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitDone();
    repeat (14) @(negedge clk);
  endtask

  // vector: chan[21:18] gain[17:15] value[14:3] mode[2:0]
  localparam logic [21:0] VEC [4] = '{
    {4'd3,  3'd2, 12'hA5C, 3'b001},
    {4'd15, 3'd4, 12'h0FF, 3'b000},
    {4'd0,  3'd6, 12'hF01, 3'b010},
    {4'd9,  3'd1, 12'h7E3, 3'b001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s0, d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 convStart", convStart, 0);
    chk("R10 irqReq", irqReq, 0);
    chk("R10 dmaReq", dmaReq, 0);
    chk("R10 muxSel", muxSel, 0);
    chk("R10 gainSel", {gainInvalid, gainSel}, 0);
    rdReg(4'd5, d); chk("R10 high byte", d, 8'h10);
    rdReg(4'd4, d); chk("R10 low byte", d, 8'h00);

    // table-driven pass
    for (int i = 0; i < 4; i++) begin
      logic [3:0] ch; logic [2:0] gn, md; logic [11:0] val;
      {ch, gn, val, md} = VEC[i];
      wrReg(4'd10, {4'hA, ch});
      wrReg(4'd9, {5'b10101, gn});
      wrReg(4'd11, {5'b0, md});
      chk("R3 muxSel", muxSel, ch);
      chk("R4 gainSel", gainSel, (gn > 4) ? 0 : gn);
      chk("R4 gainInvalid", gainInvalid, gn > 4);
      rdReg(4'd9, d); chk("R4 gain readback", d, {(gn > 4), gn});
      modelValue = val;
      d0 = dmaCount; s0 = startCount;
      wrReg(4'd12, 8'h5A);
      waitDone();
      chk("R5 one start", startCount - s0, 1);
      rdReg(4'd5, d); chk("R1 R2 high byte", d, {4'b0000, val[11:8]});
      rdReg(4'd4, d); chk("R1 low byte", d, val[7:0]);
      rdReg(4'd5, d); chk("R2 rearmed", d, {4'b0001, val[11:8]});
      rdReg(4'd10, d); chk("R3 sample chan", d, ch);
      chk("R8 R9 irqReq", irqReq, md == 3'b001);
      chk("R9 dma pulses", dmaCount - d0, (md == 3'b010) ? 1 : 0);
      wrReg(4'd8, 8'h00);
      chk("R8 cleared", irqReq, 0);
    end

    // R2: reading the high byte does not re-arm the flag
    modelValue = 12'h3C4;
    wrReg(4'd12, 8'h00);
    waitDone();
    rdReg(4'd5, d); chk("R2 first high", d[4], 0);
    rdReg(4'd5, d); chk("R2 high no side effect", d[4], 0);
    rdReg(4'd4, d); chk("R1 low", d, 8'hC4);

    // R8: sticky and re-arms after clear
    wrReg(4'd11, 8'h01);
    wrReg(4'd12, 8'h00);
    waitDone();
    chk("R8 set", irqReq, 1);
    repeat (5) @(negedge clk);
    chk("R8 sticky", irqReq, 1);
    wrReg(4'd8, 8'hFF);
    chk("R8 clear", irqReq, 0);
    wrReg(4'd12, 8'h00);
    waitDone();
    chk("R8 rearm", irqReq, 1);
    wrReg(4'd8, 8'h00);
    wrReg(4'd11, 8'h00);
    rdReg(4'd4, d);

    // R7 and R3: triggers and a channel write inside a busy window
    wrReg(4'd10, 8'h05);
    s0 = startCount;
    wrReg(4'd12, 8'h00);
    wrReg(4'd12, 8'h00);
    @(negedge clk); pacerPulse = 1'b1;
    @(negedge clk); pacerPulse = 1'b0;
    wrReg(4'd10, 8'h07);
    waitDone();
    chk("R7 dropped triggers", startCount - s0, 1);
    chk("R3 new mux", muxSel, 7);
    rdReg(4'd10, d); chk("R3 launch chan", d, 5);
    rdReg(4'd4, d);

    // R6: pacer selected, external ignored
    useExtTrig = 1'b0;
    s0 = startCount;
    @(negedge clk); extTrig = 1'b1;
    repeat (5) @(negedge clk); extTrig = 1'b0;
    waitDone();
    chk("R6 ext ignored", startCount - s0, 0);
    @(negedge clk); pacerPulse = 1'b1;
    @(negedge clk); pacerPulse = 1'b0;
    waitDone();
    chk("R6 pacer launches", startCount - s0, 1);

    // R6: external selected, pacer ignored
    useExtTrig = 1'b1;
    s0 = startCount;
    @(negedge clk); pacerPulse = 1'b1;
    @(negedge clk); pacerPulse = 1'b0;
    waitDone();
    chk("R6 pacer ignored", startCount - s0, 0);
    @(negedge clk); extTrig = 1'b1;
    repeat (5) @(negedge clk); extTrig = 1'b0;
    waitDone();
    chk("R6 ext edge launches", startCount - s0, 1);

    // R9: mode 000 raises nothing
    d0 = dmaCount;
    wrReg(4'd12, 8'h00);
    waitDone();
    chk("R9 none irq", irqReq, 0);
    chk("R9 none dma", dmaCount - d0, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule